// File: doc/BRIEF.md
# Self-Testing Slow-Clock Guard

This block watches the external clock that drives a processor core and raises an alarm when that clock stops or slows past a set limit. The alarm is the only source of the core's internal reset. While it is high, the core is held in reset, and the block's own data register and output bus are forced to zero.

The detector also takes part in every reset. An external reset request never reaches the core reset directly. It only switches a clock divider into the path the detector watches. The slowed clock then has to trip the detector. The resulting alarm turns the divider off again, and the core may start only after that whole chain has completed. If the detector is disabled, the chain can never finish, so the core stays stopped.

Edge gaps are timed with a free-running reference clock. That clock is the clock of every register in the block. The external clock is treated as a data input: it passes through a two-flop synchronizer before the detector sees it. The data path is a single plain register. It has no valid/ready handshake, because it captures whenever the core is running and `load` is high.

Top module: `lowclk_guard`

## Requirements
- R1: The detector watches a single signal: the divided clock while the divider is active, otherwise the synchronized external clock. `alarm` is 1 in the reference cycle after LIMIT consecutive reference cycles have passed without a level change of that signal. `alarm` drops one cycle after a change is seen.
- R2: `core_rst` is high in exactly the cycles in which `alarm` is high. In those cycles `core_run` is 0.
- R3: `bus_out` is all zeros whenever `core_run` is 0. An alarm clears the held data register, so old data does not reappear after the alarm ends.
- R4: A one-cycle pulse on `ext_rst_req` does not raise `core_rst` in the following cycle. Its only direct effect is that `div_active` becomes 1 in the next cycle.
- R5: While `div_active` is 1, the watched signal toggles once for every DIV_EDGES synchronized edges of the external clock. A normal external clock therefore trips the alarm.
- R6: If `alarm` is high while the divider is armed, and no new request is present, `div_active` is 0 in the next cycle. `test_passed` becomes 1 once the alarm has subsequently dropped.
- R7: After power-up `core_run` stays 0 until `test_passed` is 1. From then on, `core_run` equals `test_passed` AND NOT `alarm`.
- R8: With `sense_en` low, `alarm` stays 0 even if the clock stops. An external request then leaves `div_active` at 1 and `core_run` at 0 indefinitely.
- R9: When `core_run` is 1 and `load` is 1, `data_in` is captured, and `bus_out` shows it from the next cycle.
- R10: During power reset, and in the first cycle after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; clocks every register |
| pwr_rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_clk | input | 1 | External clock under supervision (sampled as data) |
| ext_rst_req | input | 1 | External reset request; arms the divider |
| sense_en | input | 1 | Enables alarm generation |
| load | input | 1 | Capture strobe for the held data register |
| data_in | input | DATA_W | Data to capture |
| core_rst | output | 1 | Internal core reset, driven only by the alarm |
| core_run | output | 1 | Core run enable |
| div_active | output | 1 | Clock divider currently switched into the detector path |
| alarm | output | 1 | Slow- or stopped-clock alarm |
| test_passed | output | 1 | Reset self-test sequence has completed |
| bus_out | output | DATA_W | Held data, forced to zero unless running |

## Verification
The assertions check the invariants that hold in every cycle:
- `core_run` never goes high without `test_passed`, and never while the alarm is high.
- The bus is zero whenever the core is not running.
- A disabled sensor raises no alarm in the next cycle.
- The divider turns on only after a request, and an alarm during the armed phase turns it off.

Three things need stimulus over many cycles, so only the bench scenarios show them:
- the exact gap length at which the alarm fires;
- the divided clock really tripping the detector;
- the permanent lock-out when the sensor is disabled.

A behavioural model in the bench follows all outputs cycle by cycle through those scenarios.

// File: rtl/lowclk_guard_pkg.sv
package lowclk_guard_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_ARMED   = 2'd1,
    SEQ_RECOVER = 2'd2,
    SEQ_DONE    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/lcg_sync.sv
module lcg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic edge_out
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign sync_out = chain[STAGES-1];
  assign edge_out = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/lcg_divider.sv
module lcg_divider #(
  parameter int DIV_EDGES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic src_edge,
  output logic div_clk
);
  localparam int DIV_W = (DIV_EDGES > 2) ? $clog2(DIV_EDGES) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_EDGES - 1);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_clk <= 1'b0;
    end else if (!active) begin
      cnt     <= '0;
      div_clk <= 1'b0;
    end else if (src_edge) begin
      if (cnt == LAST) begin
        cnt     <= '0;
        div_clk <= ~div_clk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcg_gap_detector.sv
module lcg_gap_detector #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic watched,
  output logic alarm
);
  localparam int GAP_W = $clog2(LIMIT + 1);
  localparam logic [GAP_W-1:0] LIM = GAP_W'(LIMIT);

  logic [GAP_W-1:0] gap, gap_next;
  logic             watched_prev;
  logic             seen;

  assign seen = watched ^ watched_prev;

  always_comb begin
    if (seen)            gap_next = '0;
    else if (gap >= LIM) gap_next = LIM;
    else                 gap_next = gap + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap          <= '0;
      watched_prev <= 1'b0;
      alarm        <= 1'b0;
    end else begin
      gap          <= gap_next;
      watched_prev <= watched;
      alarm        <= enable && (gap_next >= LIM);
    end
  end
endmodule

// File: rtl/lcg_reset_seq.sv
module lcg_reset_seq
  import lowclk_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic request,
  input  logic alarm,
  output logic div_on,
  output logic passed
);
  seq_state_e state, state_next;

  always_comb begin
    state_next = state;
    if (request) begin
      state_next = SEQ_ARMED;
    end else begin
      unique case (state)
        SEQ_IDLE:    state_next = SEQ_IDLE;
        SEQ_ARMED:   if (alarm)  state_next = SEQ_RECOVER;
        SEQ_RECOVER: if (!alarm) state_next = SEQ_DONE;
        SEQ_DONE:    state_next = SEQ_DONE;
        default:     state_next = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= state_next;
  end

  assign div_on = (state == SEQ_ARMED);
  assign passed = (state == SEQ_DONE);
endmodule

// File: rtl/lowclk_guard.sv
module lowclk_guard #(
  parameter int LIMIT       = 16,
  parameter int DIV_EDGES   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 16
) (
  input  logic              ref_clk,
  input  logic              pwr_rst_n,
  input  logic              ext_clk,
  input  logic              ext_rst_req,
  input  logic              sense_en,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  output logic              core_rst,
  output logic              core_run,
  output logic              div_active,
  output logic              alarm,
  output logic              test_passed,
  output logic [DATA_W-1:0] bus_out
);
  logic ext_sync, ext_edge, div_clk, watched;
  logic [DATA_W-1:0] held_q;

  lcg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(ref_clk), .rst_n(pwr_rst_n), .async_in(ext_clk),
    .sync_out(ext_sync), .edge_out(ext_edge)
  );

  lcg_divider #(.DIV_EDGES(DIV_EDGES)) u_div (
    .clk(ref_clk), .rst_n(pwr_rst_n), .active(div_active),
    .src_edge(ext_edge), .div_clk(div_clk)
  );

  assign watched = div_active ? div_clk : ext_sync;

  lcg_gap_detector #(.LIMIT(LIMIT)) u_gap (
    .clk(ref_clk), .rst_n(pwr_rst_n), .enable(sense_en),
    .watched(watched), .alarm(alarm)
  );

  lcg_reset_seq u_seq (
    .clk(ref_clk), .rst_n(pwr_rst_n), .request(ext_rst_req),
    .alarm(alarm), .div_on(div_active), .passed(test_passed)
  );

  assign core_rst = alarm;
  assign core_run = test_passed & ~alarm;

  always_ff @(posedge ref_clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n)           held_q <= '0;
    else if (alarm)           held_q <= '0;
    else if (core_run && load) held_q <= data_in;
  end

  assign bus_out = core_run ? held_q : '0;
endmodule

// File: rtl/lowclk_guard_chk.sv
module lowclk_guard_chk #(
  parameter int DATA_W = 16
) (
  input logic              ref_clk,
  input logic              pwr_rst_n,
  input logic              ext_rst_req,
  input logic              sense_en,
  input logic              core_rst,
  input logic              core_run,
  input logic              div_active,
  input logic              alarm,
  input logic              test_passed,
  input logic [DATA_W-1:0] bus_out
);
  // R2: an active reset leaves the core stopped
  a_r2_rst_stops_core: assert property (@(posedge ref_clk) disable iff (!pwr_rst_n)
    core_rst |-> !core_run);
  // R3: bus is blank while stopped
  a_r3_bus_zero: assert property (@(posedge ref_clk) disable iff (!pwr_rst_n)
    !core_run |-> (bus_out == '0));
  // R7: no run without a completed self-test
  a_r7_run_needs_pass: assert property (@(posedge ref_clk) disable iff (!pwr_rst_n)
    core_run |-> (test_passed && !alarm));
  // R8: disabled sensor yields no alarm
  a_r8_disabled_quiet: assert property (@(posedge ref_clk) disable iff (!pwr_rst_n)
    !sense_en |=> !alarm);
  // R6: alarm while armed switches the divider off
  a_r6_div_off: assert property (@(posedge ref_clk) disable iff (!pwr_rst_n)
    (div_active && alarm && !ext_rst_req) |=> !div_active);
  // R4: divider only switches in after a request
  a_r4_div_from_req: assert property (@(posedge ref_clk) disable iff (!pwr_rst_n)
    $rose(div_active) |-> $past(ext_rst_req));
  // R1: alarm only rises with the sensor enabled
  a_r1_alarm_enabled: assert property (@(posedge ref_clk) disable iff (!pwr_rst_n)
    $rose(alarm) |-> $past(sense_en));
endmodule

bind lowclk_guard lowclk_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .ref_clk(ref_clk), .pwr_rst_n(pwr_rst_n), .ext_rst_req(ext_rst_req),
  .sense_en(sense_en), .core_rst(core_rst), .core_run(core_run),
  .div_active(div_active), .alarm(alarm), .test_passed(test_passed),
  .bus_out(bus_out)
);

// File: tb/tb_lowclk_guard.sv
`timescale 1ns/1ps
module tb_lowclk_guard;
  localparam int LIMIT = 16;
  localparam int DIV_EDGES = 8;
  localparam int DATA_W = 16;
  localparam int HALF = 4;

  logic ref_clk = 1'b0;
  logic pwr_rst_n = 1'b0;
  logic ext_clk = 1'b0;
  logic ext_rst_req = 1'b0;
  logic sense_en = 1'b1;
  logic load = 1'b0;
  logic [DATA_W-1:0] data_in = '0;
  logic core_rst, core_run, div_active, alarm, test_passed;
  logic [DATA_W-1:0] bus_out;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;
  bit ext_run = 1'b1;
  int ext_cnt = 0;
  bit done = 1'b0;

  always #2 ref_clk = ~ref_clk;

  lowclk_guard #(.LIMIT(LIMIT), .DIV_EDGES(DIV_EDGES), .SYNC_STAGES(2), .DATA_W(DATA_W)) dut (
    .ref_clk(ref_clk), .pwr_rst_n(pwr_rst_n), .ext_clk(ext_clk),
    .ext_rst_req(ext_rst_req), .sense_en(sense_en), .load(load), .data_in(data_in),
    .core_rst(core_rst), .core_run(core_run), .div_active(div_active),
    .alarm(alarm), .test_passed(test_passed), .bus_out(bus_out)
  );

  // External clock stimulus, driven away from the active edge
  always @(negedge ref_clk) begin
    if (ext_run) begin
      if (ext_cnt == HALF - 1) begin
        ext_clk <= ~ext_clk;
        ext_cnt <= 0;
      end else begin
        ext_cnt <= ext_cnt + 1;
      end
    end
  end

  // Behavioural reference model
  int m_s1, m_s2, m_eprev, m_dcnt, m_dclk, m_mprev, m_gap, m_alarm, m_data;
  int m_stage; // 0 idle, 1 divider on, 2 waiting for alarm to end, 3 passed
  int t_ee, t_mon, t_me, t_gapn, t_run;

  function automatic int exp_run();
    return (m_stage == 3 && m_alarm == 0) ? 1 : 0;
  endfunction

  always @(posedge ref_clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      m_s1 = 0; m_s2 = 0; m_eprev = 0; m_dcnt = 0; m_dclk = 0;
      m_mprev = 0; m_gap = 0; m_alarm = 0; m_data = 0; m_stage = 0;
    end else begin
      t_ee = (m_s2 != m_eprev) ? 1 : 0;
      t_mon = (m_stage == 1) ? m_dclk : m_s2;
      t_me = (t_mon != m_mprev) ? 1 : 0;
      t_gapn = t_me ? 0 : ((m_gap >= LIMIT) ? LIMIT : m_gap + 1);
      t_run = exp_run();
      if (m_alarm != 0) m_data = 0;
      else if (t_run != 0 && load) m_data = int'(data_in);
      if (m_stage != 1) begin
        m_dcnt = 0; m_dclk = 0;
      end else if (t_ee != 0) begin
        if (m_dcnt == DIV_EDGES - 1) begin m_dcnt = 0; m_dclk = 1 - m_dclk; end
        else m_dcnt = m_dcnt + 1;
      end
      if (ext_rst_req) m_stage = 1;
      else if (m_stage == 1 && m_alarm != 0) m_stage = 2;
      else if (m_stage == 2 && m_alarm == 0) m_stage = 3;
      m_mprev = t_mon;
      m_eprev = m_s2;
      m_s2 = m_s1;
      m_s1 = ext_clk ? 1 : 0;
      m_gap = t_gapn;
      m_alarm = (sense_en && t_gapn >= LIMIT) ? 1 : 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge ref_clk) begin
    cycles++;
    if (pwr_rst_n && !done) begin
      check(int'(alarm) == m_alarm, "R1 alarm", int'(alarm), m_alarm);
      check(int'(core_rst) == m_alarm, "R2 core_rst", int'(core_rst), m_alarm);
      check(int'(div_active) == ((m_stage == 1) ? 1 : 0), "R5 div_active", int'(div_active), (m_stage == 1) ? 1 : 0);
      check(int'(test_passed) == ((m_stage == 3) ? 1 : 0), "R6 test_passed", int'(test_passed), (m_stage == 3) ? 1 : 0);
      check(int'(core_run) == exp_run(), "R7 core_run", int'(core_run), exp_run());
      check(int'(bus_out) == (exp_run() != 0 ? m_data : 0), "R3 bus_out", int'(bus_out), exp_run() != 0 ? m_data : 0);
    end
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic pulse_req();
    @(negedge ref_clk); ext_rst_req = 1'b1;
    @(negedge ref_clk); ext_rst_req = 1'b0;
  endtask

  task automatic wait_for(input int which, input int limit_cyc, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < limit_cyc && !seen; i++) begin
      @(negedge ref_clk);
      if (which == 0 && alarm) seen = 1'b1;
      if (which == 1 && test_passed) seen = 1'b1;
    end
  endtask

  bit got;

  initial begin
    // R10: outputs at zero during and right after power reset
    step(4);
    check(alarm == 0 && core_rst == 0 && core_run == 0 && div_active == 0 && test_passed == 0 && bus_out == 0,
          "R10 reset state", int'(core_run), 0);
    pwr_rst_n = 1'b1;
    @(negedge ref_clk);
    check(alarm == 0 && core_run == 0 && test_passed == 0, "R10 after release", int'(alarm), 0);

    // R7: fast clock, no request: core never starts, bus blank
    load = 1'b1; data_in = 16'h1234;
    step(100);
    check(alarm == 0, "R1 no alarm on normal clock", int'(alarm), 0);
    check(core_run == 0, "R7 no run before self-test", int'(core_run), 0);
    check(bus_out == 0, "R3 bus blank before run", int'(bus_out), 0);
    load = 1'b0;

    // R4: request only arms the divider
    pulse_req();
    check(core_rst == 0, "R4 request gives no direct reset", int'(core_rst), 0);
    check(div_active == 1, "R4 divider armed", int'(div_active), 1);

    // R5: the divided clock trips the detector
    wait_for(0, 300, got);
    check(got, "R5 divided clock trips alarm", int'(got), 1);
    @(negedge ref_clk);
    check(div_active == 0, "R6 divider off after alarm", int'(div_active), 0);
    wait_for(1, 80, got);
    check(got, "R6 self-test completes", int'(got), 1);
    @(negedge ref_clk);
    check(core_run == 1, "R7 core runs after self-test", int'(core_run), 1);

    // R9: capture data while running
    load = 1'b1; data_in = 16'hA5C3;
    @(negedge ref_clk); load = 1'b0;
    check(bus_out == 16'hA5C3, "R9 capture", int'(bus_out), 16'hA5C3);

    // R1/R2/R3: stopped clock
    ext_run = 1'b0;
    step(LIMIT + 8);
    check(alarm == 1, "R1 stopped clock alarms", int'(alarm), 1);
    check(core_rst == 1 && core_run == 0, "R2 reset while alarm", int'(core_run), 0);
    check(bus_out == 0, "R3 bus blank on alarm", int'(bus_out), 0);
    ext_run = 1'b1;
    step(12);
    check(alarm == 0 && core_run == 1, "R1 alarm ends with clock", int'(core_run), 1);
    check(bus_out == 0, "R3 data cleared by alarm", int'(bus_out), 0);

    // R8: disabled sensor locks the core out
    sense_en = 1'b0;
    pulse_req();
    step(300);
    check(alarm == 0, "R8 no alarm when disabled", int'(alarm), 0);
    check(div_active == 1 && core_run == 0 && test_passed == 0, "R8 stuck in reset", int'(core_run), 0);
    ext_run = 1'b0;
    step(60);
    check(alarm == 0, "R8 stopped clock ignored when disabled", int'(alarm), 0);
    ext_run = 1'b1;
    step(10);

    // Re-enable: sequence completes
    sense_en = 1'b1;
    wait_for(1, 400, got);
    check(got, "R6 self-test after re-enable", int'(got), 1);
    step(3);
    check(core_run == 1, "R7 run after re-enable", int'(core_run), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule